// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

This block collects up to 32 level inputs and presents them to a processor as two request lines, a normal one and a fast one. Each input first passes through a per-source polarity stage and an optional sticky capture. A routing bit then assigns the source to exactly one of the two banks. Inside a bank, the source is masked by that bank's enable set and by the bank's priority threshold. A bank's request line is high for as long as any of its sources survives this masking.

Software uses a small word-addressed register bus. Within a bank there are set-only and clear-only enable ports. A current-source register names the pending source with the numerically lowest 4-bit priority, and a read-to-acknowledge register releases the sticky captures of that bank. Polarity, sticky mode, routing and the per-source priorities are shared registers that both banks see.

Top module: `intc_dual_top`

## Requirements
- R1: After a synchronous reset, no source is enabled in either bank, both request outputs are low, the polarity word (0x200) reads all ones, the sticky word (0x204) and the route word (0x208) read zero, every priority word reads zero, and both threshold registers (bank offset 0x2C) read 0xF.
- R2: Writing the enable register (bank offset 0x08) sets the enable of each source whose bit is 1. Writing the disable register (bank offset 0x0C) clears the enable of each source whose bit is 1. Zero bits leave an enable unchanged. Both offsets read back the enable set.
- R3: A polarity bit of 1 passes its input unchanged, and a polarity bit of 0 inverts it. The raw register (bank offset 0x04) shows the post-polarity pending state of the bank's sources before enable masking.
- R4: The status register (bank offset 0x00) equals raw AND enable AND the threshold pass. A bank's request output is registered and is high exactly one cycle after that bank's status becomes nonzero.
- R5: The current register (bank offset 0x20) returns the status source with the lowest priority value, with ties going to the lower source number. It returns 0 when status is zero.
- R6: A source passes its bank's threshold when its priority is less than or equal to the threshold, so a threshold of 0xF passes every priority.
- R7: A source whose sticky bit is 1 stays pending after its active level ends, until its bank is acknowledged. A source whose sticky bit is 0 follows its level.
- R8: A read of a bank's acknowledge register (bank offset 0x28) returns that bank's current value and clears the sticky captures of only the sources routed to that bank.
- R9: A route bit of 1 places its source in the fast bank (base 0x100). A route bit of 0 places it in the normal bank (base 0x000). A source never appears in both banks.
- R10: Priority words sit at 0x300 + 4*n and hold 4 bits; their upper bits read zero. Reads of unmapped word addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; data returns on the next cycle |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 32 | Interrupt source inputs |
| irq_norm_o | output | 1 | Normal bank request |
| irq_fast_o | output | 1 | Fast bank request |

## Verification
The bound checker watches several properties on every cycle. It confirms that no status bit lies outside the enable set, that the two banks never share a status bit, and that the request line follows nonzero status with a one-cycle lag. It also confirms that any source named as current is itself in status and within the threshold, and that an enable write sets every written bit. The selection order among competing priorities and index ties can only be shown by the bench's directed scenarios. The same holds for the inclusive threshold edge, sticky capture surviving a dropped input, an acknowledge on one bank leaving the other bank's captures intact, and the polarity inversion.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // page select: address bits 11:8
  localparam logic [3:0] PG_NORM   = 4'h0;
  localparam logic [3:0] PG_FAST   = 4'h1;
  localparam logic [3:0] PG_SHARED = 4'h2;
  localparam logic [3:0] PG_PRIO   = 4'h3;

  // per-bank offsets
  localparam logic [7:0] OF_STAT = 8'h00;
  localparam logic [7:0] OF_RAW  = 8'h04;
  localparam logic [7:0] OF_EN   = 8'h08;
  localparam logic [7:0] OF_DIS  = 8'h0C;
  localparam logic [7:0] OF_CUR  = 8'h20;
  localparam logic [7:0] OF_ACK  = 8'h28;
  localparam logic [7:0] OF_THR  = 8'h2C;

  // shared page offsets
  localparam logic [7:0] OF_POL  = 8'h00;
  localparam logic [7:0] OF_STK  = 8'h04;
  localparam logic [7:0] OF_RTE  = 8'h08;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic thr_wr;
    logic ack;
  } bank_ctl_t;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] lines,
  input  logic [NUM_SRC-1:0] pol_keep,
  input  logic [NUM_SRC-1:0] sticky,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic lvl_q;
    logic cap_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q <= 1'b0;
        cap_q <= 1'b0;
      end else begin
        lvl_q <= pol_keep[g] ? lines[g] : ~lines[g];
        if (clr_mask[g] || !sticky[g]) cap_q <= 1'b0;
        else if (lvl_q)                cap_q <= 1'b1;
      end
    end
    assign pend[g] = sticky[g] ? (lvl_q | cap_q) : lvl_q;
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              pend,
  input  logic [NUM_SRC-1:0]              member,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  input  intc_pkg::bank_ctl_t             ctl,
  input  logic [NUM_SRC-1:0]              wmask,
  input  logic [PRIO_W-1:0]               thr_wdata,
  output logic [NUM_SRC-1:0]              raw,
  output logic [NUM_SRC-1:0]              status,
  output logic [NUM_SRC-1:0]              en,
  output logic [PRIO_W-1:0]               thr,
  output logic [IDX_W-1:0]                cur,
  output logic                            irq_q
);
  logic [NUM_SRC-1:0] pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      thr   <= '1;
      irq_q <= 1'b0;
    end else begin
      if (ctl.en_set)      en <= en | wmask;
      else if (ctl.en_clr) en <= en & ~wmask;
      if (ctl.thr_wr) thr <= thr_wdata;
      irq_q <= |status;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pass
    assign pass[g] = (prio[g] <= thr);
  end

  assign raw    = pend & member;
  assign status = raw & en & pass;

  // lowest priority value wins; strict compare keeps the lower index on ties
  always_comb begin
    logic [PRIO_W:0] best;
    best = {1'b1, {PRIO_W{1'b0}}};
    cur  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (status[i] && ({1'b0, prio[i]} < best)) begin
        best = {1'b0, prio[i]};
        cur  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_dual_top.sv
module intc_dual_top #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int NBANK  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] irq_lines,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  import intc_pkg::*;

  logic [3:0] page;
  logic [7:0] ofs;
  logic       aligned;
  logic [5:0] pidx;
  logic       pidx_ok;

  logic [NUM_SRC-1:0]             pol_q, stk_q, rte_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             pend, clr_mask;

  bank_ctl_t [NBANK-1:0]              ctl;
  logic [NBANK-1:0][NUM_SRC-1:0]      raw_b, stat_b, en_b;
  logic [NBANK-1:0][PRIO_W-1:0]       thr_b;
  logic [NBANK-1:0][IDX_W-1:0]        cur_b;
  logic [NBANK-1:0]                   irq_b;

  assign page    = bus_addr[11:8];
  assign ofs     = bus_addr[7:0];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign pidx    = bus_addr[7:2];
  assign pidx_ok = (int'(pidx) < NUM_SRC);

  // shared configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '1;
      stk_q  <= '0;
      rte_q  <= '0;
      prio_q <= '0;
    end else if (bus_wr && aligned) begin
      if (page == PG_SHARED) begin
        if (ofs == OF_POL) pol_q <= bus_wdata[NUM_SRC-1:0];
        if (ofs == OF_STK) stk_q <= bus_wdata[NUM_SRC-1:0];
        if (ofs == OF_RTE) rte_q <= bus_wdata[NUM_SRC-1:0];
      end
      if (page == PG_PRIO && pidx_ok)
        prio_q[pidx[IDX_W-1:0]] <= bus_wdata[PRIO_W-1:0];
    end
  end

  assign clr_mask = ({NUM_SRC{ctl[0].ack}} & ~rte_q) |
                    ({NUM_SRC{ctl[1].ack}} &  rte_q);

  intc_src_cond #(.NUM_SRC(NUM_SRC)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .lines    (irq_lines),
    .pol_keep (pol_q),
    .sticky   (stk_q),
    .clr_mask (clr_mask),
    .pend     (pend)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = aligned && (page == 4'(b));
    assign ctl[b].en_set = bus_wr && hit && (ofs == OF_EN);
    assign ctl[b].en_clr = bus_wr && hit && (ofs == OF_DIS);
    assign ctl[b].thr_wr = bus_wr && hit && (ofs == OF_THR);
    assign ctl[b].ack    = bus_rd && hit && (ofs == OF_ACK);

    intc_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .pend      (pend),
      .member    ((b == 1) ? rte_q : ~rte_q),
      .prio      (prio_q),
      .ctl       (ctl[b]),
      .wmask     (bus_wdata[NUM_SRC-1:0]),
      .thr_wdata (bus_wdata[PRIO_W-1:0]),
      .raw       (raw_b[b]),
      .status    (stat_b[b]),
      .en        (en_b[b]),
      .thr       (thr_b[b]),
      .cur       (cur_b[b]),
      .irq_q     (irq_b[b])
    );
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (aligned) begin
        if (page == PG_NORM || page == PG_FAST) begin
          case (ofs)
            OF_STAT:        bus_rdata <= DATA_W'(stat_b[page[0]]);
            OF_RAW:         bus_rdata <= DATA_W'(raw_b[page[0]]);
            OF_EN, OF_DIS:  bus_rdata <= DATA_W'(en_b[page[0]]);
            OF_CUR, OF_ACK: bus_rdata <= DATA_W'(cur_b[page[0]]);
            OF_THR:         bus_rdata <= DATA_W'(thr_b[page[0]]);
            default:        bus_rdata <= '0;
          endcase
        end else if (page == PG_SHARED) begin
          case (ofs)
            OF_POL:  bus_rdata <= DATA_W'(pol_q);
            OF_STK:  bus_rdata <= DATA_W'(stk_q);
            OF_RTE:  bus_rdata <= DATA_W'(rte_q);
            default: bus_rdata <= '0;
          endcase
        end else if (page == PG_PRIO && pidx_ok) begin
          bus_rdata <= DATA_W'(prio_q[pidx[IDX_W-1:0]]);
        end
      end
    end
  end

  assign irq_norm_o = irq_b[0];
  assign irq_fast_o = irq_b[1];
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            bus_wr,
  input logic [11:0]                     bus_addr,
  input logic [NUM_SRC-1:0]              wmask,
  input logic [NUM_SRC-1:0]              stat_n,
  input logic [NUM_SRC-1:0]              stat_f,
  input logic [NUM_SRC-1:0]              en_n,
  input logic [IDX_W-1:0]                cur_n,
  input logic [PRIO_W-1:0]               thr_n,
  input logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  input logic                            irq_norm
);
  p_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_n & ~en_n) == '0);

  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 12'h008) |=> ((en_n & $past(wmask)) == $past(wmask)));

  p_irq_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (|stat_n) |=> irq_norm);

  p_irq_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !(|stat_n) |=> !irq_norm);

  p_cur_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (|stat_n) |-> stat_n[cur_n]);

  p_cur_thr_r6: assert property (@(posedge clk) disable iff (rst)
    (|stat_n) |-> (prio[cur_n] <= thr_n));

  p_disjoint_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_n & stat_f) == '0);
endmodule

bind intc_dual_top intc_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr[11:0]),
  .wmask    (bus_wdata[NUM_SRC-1:0]),
  .stat_n   (stat_b[0]),
  .stat_f   (stat_b[1]),
  .en_n     (en_b[0]),
  .cur_n    (cur_b[0]),
  .thr_n    (thr_b[0]),
  .prio     (prio_q),
  .irq_norm (irq_norm_o)
);

// File: tb/intc_dual_top_tb_top.sv
`timescale 1ns/1ps
module intc_dual_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_lines = '0;
  logic        irq_norm_o, irq_fast_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  intc_dual_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rd_d) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_irq(input logic n, input logic f, input string t);
    total++;
    if (irq_norm_o !== n || irq_fast_o !== f) begin
      bad++;
      $display("FAIL %s act=%b%b exp=%b%b", t, irq_norm_o, irq_fast_o, n, f);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, 1'b0, "R1 outputs");
    rd(12'h000, 32'h0, "R1 status");
    rd(12'h008, 32'h0, "R1 normal enable");
    rd(12'h108, 32'h0, "R1 fast enable");
    rd(12'h200, 32'hFFFF_FFFF, "R1 polarity");
    rd(12'h204, 32'h0, "R1 sticky");
    rd(12'h208, 32'h0, "R1 route");
    rd(12'h02C, 32'hF, "R1 normal threshold");
    rd(12'h12C, 32'hF, "R1 fast threshold");
    rd(12'h33C, 32'h0, "R1 priority 15");
    rd(12'h020, 32'h0, "R5 current idle");
    // R10 map details
    rd(12'h210, 32'h0, "R10 unmapped");
    wr(12'h300, 32'hFFFF_FFF5);
    rd(12'h300, 32'h5, "R10 priority width");
    wr(12'h300, 32'h0);
    // R2 set and clear ports
    wr(12'h008, 32'hF0);
    wr(12'h008, 32'h01);
    rd(12'h008, 32'hF1, "R2 set keeps others");
    wr(12'h00C, 32'h10);
    rd(12'h00C, 32'hE1, "R2 clear one");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h008, 32'h0, "R2 clear all");
    // R3 R4 level sources
    wr(12'h008, 32'h28);
    @(negedge clk); irq_lines = 32'h88;
    settle();
    chk_irq(1'b1, 1'b0, "R4 request high");
    rd(12'h000, 32'h08, "R4 status masked");
    rd(12'h004, 32'h88, "R3 raw unmasked");
    rd(12'h020, 32'd3, "R5 single source");
    irq_lines = 32'h0;
    settle();
    chk_irq(1'b0, 1'b0, "R4 request low");
    rd(12'h004, 32'h0, "R3 raw idle");
    // R3 polarity
    wr(12'h200, 32'hFFFF_FDFF);
    settle();
    rd(12'h004, 32'h200, "R3 inverted low input");
    rd(12'h000, 32'h0, "R4 not enabled");
    wr(12'h008, 32'h200);
    settle();
    chk_irq(1'b1, 1'b0, "R3 inverted request");
    rd(12'h020, 32'd9, "R3 inverted current");
    irq_lines = 32'h200;
    settle();
    rd(12'h004, 32'h0, "R3 inverted high input");
    irq_lines = 32'h0;
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h00C, 32'hFFFF_FFFF);
    // R5 R6 priority and threshold
    wr(12'h008, 32'h50);
    wr(12'h310, 32'd5);
    wr(12'h318, 32'd2);
    irq_lines = 32'h50;
    settle();
    rd(12'h020, 32'd6, "R5 lower value wins");
    wr(12'h318, 32'd5);
    rd(12'h020, 32'd4, "R5 tie lower index");
    wr(12'h02C, 32'd3);
    settle();
    rd(12'h000, 32'h0, "R6 above threshold");
    chk_irq(1'b0, 1'b0, "R6 request blocked");
    rd(12'h020, 32'h0, "R5 none passes");
    wr(12'h02C, 32'd5);
    settle();
    rd(12'h000, 32'h50, "R6 equal passes");
    chk_irq(1'b1, 1'b0, "R6 request equal");
    irq_lines = 32'h0;
    wr(12'h02C, 32'hF);
    wr(12'h310, 32'd0);
    wr(12'h318, 32'd0);
    wr(12'h00C, 32'hFFFF_FFFF);
    // R7 R8 sticky capture and acknowledge
    wr(12'h204, 32'h1000);
    wr(12'h008, 32'h3000);
    @(negedge clk); irq_lines = 32'h1000;
    repeat (2) @(negedge clk);
    irq_lines = 32'h0;
    settle();
    rd(12'h000, 32'h1000, "R7 sticky held");
    chk_irq(1'b1, 1'b0, "R7 sticky request");
    rd(12'h128, 32'h0, "R8 fast ack value");
    rd(12'h000, 32'h1000, "R8 other bank kept");
    rd(12'h028, 32'd12, "R8 ack returns current");
    settle();
    rd(12'h000, 32'h0, "R8 ack cleared");
    chk_irq(1'b0, 1'b0, "R8 request cleared");
    @(negedge clk); irq_lines = 32'h2000;
    repeat (2) @(negedge clk);
    irq_lines = 32'h0;
    settle();
    rd(12'h000, 32'h0, "R7 level source follows");
    wr(12'h204, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF);
    // R9 routing
    wr(12'h208, 32'h0010_0000);
    wr(12'h108, 32'h0010_0000);
    wr(12'h008, 32'h0010_0000);
    irq_lines = 32'h0010_0000;
    settle();
    chk_irq(1'b0, 1'b1, "R9 fast request only");
    rd(12'h120, 32'd20, "R9 fast current");
    rd(12'h104, 32'h0010_0000, "R9 fast raw");
    rd(12'h004, 32'h0, "R9 normal raw excludes");
    rd(12'h000, 32'h0, "R9 normal status excludes");
    irq_lines = 32'h0;
    settle();
    chk_irq(1'b0, 1'b0, "R9 fast request low");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard left=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule